// File: doc/BRIEF.md
# Multi-Driver Strength Resolver

This block merges two drivers of a single scalar net into one resolved value together with a strength range. Each driver, and the result, is a span on a 16-position scale. The positions run from the strongest 0 (position 0), down through the weaker 0 levels to high impedance on the 0 side (position 7). They continue from high impedance on the 1 side (position 8) up to the strongest 1 (position 15). For a position p, the level is 7-p when p < 8 and p-8 when p >= 8. Level 7 is supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small and 0 high impedance. A single position is a known signal. A span is an ambiguous one: it may cover several strengths, or values on both sides.

The result is the smallest span that contains every outcome the two drivers could produce, taking each possible point of one driver against each possible point of the other. When two points meet, the stronger one decides. A tie between opposing values is decided by the net kind. A 3-bit selector picks that kind: plain, wired-AND, wired-OR, pulled-low or pulled-high. More than two drivers are resolved by chaining instances, feeding one result in as a driver of the next.

Top module: `strn_resolver`

## Requirements
- R1: When both drivers are single positions at different levels, the output equals the stronger driver's position (lo = hi = that position).
- R2: Two opposing points at equal nonzero level s give, on a plain net (selector 0), the span from 7-s to 8+s. On wired-AND (selector 1) they give position 7-s only, and on wired-OR (selector 2) position 8+s only.
- R3: Against a known driver, the levels of an ambiguous driver that are stronger than the known one appear unchanged in the output span.
- R4: When the ambiguous and known drivers share a value, the ambiguous levels at or below the known level are dropped, and the output ends at the known position.
- R5: When the ambiguous and known drivers carry different values, the output span reaches from the kept ambiguous levels down to, and including, the known driver's level on the known driver's side.
- R6: For two ambiguous drivers, the output is the hull (lowest to highest position) of all pairwise outcomes, and out_lo never exceeds out_hi.
- R7: Two high-impedance points on a plain, wired-AND or wired-OR net resolve to z, encoded as lo = 7, hi = 8.
- R8: On a pulled-low net (selector 3) or a pulled-high net (selector 4), the result is merged once more with a pull driver at position 2 or 13. An undriven net therefore gives that pull position, any outcome weaker than pull is replaced by it, and z never appears.
- R9: A driver whose default flag is set is a strong drive: position 1 when its upper endpoint is below 8, position 14 otherwise.
- R10: The two endpoints of a driver may be given in either order; the smaller is taken as the low end.
- R11: Swapping the two drivers leaves the output unchanged.
- R12: The selector codes 5 to 7 behave as a plain net.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_lo | input | 4 | First endpoint of driver A |
| a_hi | input | 4 | Second endpoint of driver A |
| a_dflt | input | 1 | Driver A takes default strong strength |
| b_lo | input | 4 | First endpoint of driver B |
| b_hi | input | 4 | Second endpoint of driver B |
| b_dflt | input | 1 | Driver B takes default strong strength |
| net_sel | input | 3 | Net kind: 0 plain, 1 wired-AND, 2 wired-OR, 3 pulled-low, 4 pulled-high |
| out_lo | output | 4 | Low position of the resolved span |
| out_hi | output | 4 | High position of the resolved span |

## Verification
The case that needs care is a single input pattern in which the same resolution sees two effects at once. An ambiguous driver's span straddles the other driver's level, so dominance and an equal-level tie both take part, and on a pulled net the pull stage acts on top of that. Vectors are chosen so that one pair of drivers hits the tie rule and the dominance rules together; for example, a span from supply-0 to medium-0 is set against a known large-1. The bench checks the exact endpoints worked out by hand from the pairwise rules. Every vector is then applied a second time with the drivers swapped, and the same endpoints are expected.

// File: rtl/strn_pkg.sv
package strn_pkg;
  localparam int LVL_W = 3;
  localparam int IDX_W = LVL_W + 1;
  localparam int NPOS  = 1 << IDX_W;
  localparam int ZMID  = NPOS / 2;

  typedef logic [IDX_W-1:0] pos_t;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef struct packed {
    pos_t lo;
    pos_t hi;
  } span_t;

  typedef enum logic [1:0] {CMB_WIRE, CMB_AND, CMB_OR} comb_e;

  localparam logic [2:0] NET_WIRE = 3'd0;
  localparam logic [2:0] NET_AND  = 3'd1;
  localparam logic [2:0] NET_OR   = 3'd2;
  localparam logic [2:0] NET_PD   = 3'd3;
  localparam logic [2:0] NET_PU   = 3'd4;

  localparam lvl_t LVL_STRONG = LVL_W'((1 << LVL_W) - 2);
  localparam lvl_t LVL_PULL   = LVL_W'((1 << LVL_W) - 3);
  localparam span_t ZSPAN = '{lo: pos_t'(ZMID - 1), hi: pos_t'(ZMID)};

  function automatic lvl_t lvl_of(pos_t p);
    return p[IDX_W-1] ? p[LVL_W-1:0] : ~p[LVL_W-1:0];
  endfunction

  function automatic pos_t pos_at(logic v, lvl_t s);
    return {v, (v ? s : ~s)};
  endfunction

  // outcome of one exact point of each driver meeting on the net
  function automatic span_t pair_res(pos_t i, pos_t j, comb_e m);
    lvl_t  li;
    lvl_t  lj;
    span_t r;
    li = lvl_of(i);
    lj = lvl_of(j);
    if (li > lj)                     r = '{lo: i, hi: i};
    else if (lj > li)                r = '{lo: j, hi: j};
    else if (li == '0)               r = ZSPAN;
    else if (i[IDX_W-1] == j[IDX_W-1]) r = '{lo: i, hi: i};
    else begin
      case (m)
        CMB_AND: r = '{lo: pos_at(1'b0, li), hi: pos_at(1'b0, li)};
        CMB_OR:  r = '{lo: pos_at(1'b1, li), hi: pos_at(1'b1, li)};
        default: r = '{lo: pos_at(1'b0, li), hi: pos_at(1'b1, li)};
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/strn_drv_norm.sv
module strn_drv_norm
  import strn_pkg::*;
(
  input  pos_t  e0,
  input  pos_t  e1,
  input  logic  dflt,
  output span_t sp
);
  pos_t lo_w;
  pos_t hi_w;
  pos_t st_w;

  always_comb begin
    lo_w = (e0 <= e1) ? e0 : e1;
    hi_w = (e0 <= e1) ? e1 : e0;
    st_w = pos_at(hi_w[IDX_W-1], LVL_STRONG);
    if (dflt) sp = '{lo: st_w, hi: st_w};
    else      sp = '{lo: lo_w, hi: hi_w};
  end
endmodule

// File: rtl/strn_merge.sv
module strn_merge
  import strn_pkg::*;
(
  input  span_t sa,
  input  span_t sb,
  input  comb_e mode,
  output span_t sy
);
  always_comb begin
    pos_t  pi;
    pos_t  pj;
    span_t r;
    pos_t  lo_acc;
    pos_t  hi_acc;
    lo_acc = '1;
    hi_acc = '0;
    pi = '0;
    pj = '0;
    r  = ZSPAN;
    for (int i = 0; i < NPOS; i++) begin
      for (int j = 0; j < NPOS; j++) begin
        pi = pos_t'(i);
        pj = pos_t'(j);
        if (pi >= sa.lo && pi <= sa.hi && pj >= sb.lo && pj <= sb.hi) begin
          r = pair_res(pi, pj, mode);
          if (r.lo < lo_acc) lo_acc = r.lo;
          if (r.hi > hi_acc) hi_acc = r.hi;
        end
      end
    end
    sy = '{lo: lo_acc, hi: hi_acc};
  end
endmodule

// File: rtl/strn_resolver.sv
module strn_resolver
  import strn_pkg::*;
(
  input  logic [3:0] a_lo,
  input  logic [3:0] a_hi,
  input  logic       a_dflt,
  input  logic [3:0] b_lo,
  input  logic [3:0] b_hi,
  input  logic       b_dflt,
  input  logic [2:0] net_sel,
  output logic [3:0] out_lo,
  output logic [3:0] out_hi
);
  localparam int NDRV = 2;

  pos_t  e0_arr [NDRV];
  pos_t  e1_arr [NDRV];
  logic  df_arr [NDRV];
  span_t dsp    [NDRV];

  assign e0_arr[0] = a_lo;
  assign e1_arr[0] = a_hi;
  assign df_arr[0] = a_dflt;
  assign e0_arr[1] = b_lo;
  assign e1_arr[1] = b_hi;
  assign df_arr[1] = b_dflt;

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    strn_drv_norm u_norm (
      .e0  (e0_arr[d]),
      .e1  (e1_arr[d]),
      .dflt(df_arr[d]),
      .sp  (dsp[d])
    );
  end

  comb_e mode_w;
  logic  pulled_w;
  span_t pull_sp;

  always_comb begin
    mode_w   = CMB_WIRE;
    pulled_w = 1'b0;
    pull_sp  = '{lo: pos_at(1'b0, LVL_PULL), hi: pos_at(1'b0, LVL_PULL)};
    case (net_sel)
      NET_AND: mode_w = CMB_AND;
      NET_OR:  mode_w = CMB_OR;
      NET_PD:  pulled_w = 1'b1;
      NET_PU: begin
        pulled_w = 1'b1;
        pull_sp  = '{lo: pos_at(1'b1, LVL_PULL), hi: pos_at(1'b1, LVL_PULL)};
      end
      default: mode_w = CMB_WIRE;
    endcase
  end

  span_t pair_sp;
  span_t pull_res;

  strn_merge u_pair (
    .sa  (dsp[0]),
    .sb  (dsp[1]),
    .mode(mode_w),
    .sy  (pair_sp)
  );

  strn_merge u_pull (
    .sa  (pair_sp),
    .sb  (pull_sp),
    .mode(CMB_WIRE),
    .sy  (pull_res)
  );

  assign out_lo = pulled_w ? pull_res.lo : pair_sp.lo;
  assign out_hi = pulled_w ? pull_res.hi : pair_sp.hi;
endmodule

// File: rtl/strn_resolver_chk.sv
module strn_resolver_chk
  import strn_pkg::*;
(
  input logic [3:0] a_lo,
  input logic [3:0] a_hi,
  input logic       a_dflt,
  input logic [3:0] b_lo,
  input logic [3:0] b_hi,
  input logic       b_dflt,
  input logic [2:0] net_sel,
  input logic [3:0] out_lo,
  input logic [3:0] out_hi
);
  logic known_w;
  logic tie_opp_w;
  logic all_z_w;

  always_comb begin
    known_w   = !a_dflt && !b_dflt && (a_lo == a_hi) && (b_lo == b_hi);
    tie_opp_w = known_w && (lvl_of(a_lo) == lvl_of(b_lo)) &&
                (lvl_of(a_lo) != '0) && (a_lo[3] != b_lo[3]);
    all_z_w   = !a_dflt && !b_dflt && (lvl_of(a_lo) == '0) && (lvl_of(a_hi) == '0) &&
                (lvl_of(b_lo) == '0) && (lvl_of(b_hi) == '0);

    // R6
    span_order_chk: assert (out_lo <= out_hi);

    // R1
    if (net_sel == NET_WIRE && known_w && lvl_of(a_lo) > lvl_of(b_lo))
      strong_a_wins_chk: assert (out_lo == a_lo && out_hi == a_lo);

    // R2
    if (net_sel == NET_AND && tie_opp_w)
      wand_tie_chk: assert (out_lo == out_hi && !out_hi[3]);

    // R2
    if (net_sel == NET_OR && tie_opp_w)
      wor_tie_chk: assert (out_lo == out_hi && out_lo[3]);

    // R7
    if (net_sel == NET_WIRE && all_z_w)
      undriven_z_chk: assert (out_lo == 4'd7 && out_hi == 4'd8);

    // R8
    if (net_sel == NET_PD || net_sel == NET_PU)
      pulled_no_z_chk: assert (!(out_lo == 4'd7 && out_hi == 4'd8));
  end
endmodule

bind strn_resolver strn_resolver_chk u_chk (
  .a_lo   (a_lo),
  .a_hi   (a_hi),
  .a_dflt (a_dflt),
  .b_lo   (b_lo),
  .b_hi   (b_hi),
  .b_dflt (b_dflt),
  .net_sel(net_sel),
  .out_lo (out_lo),
  .out_hi (out_hi)
);

// File: tb/sim_strn_resolver.sv
module sim_strn_resolver;
  logic       clk;
  logic [3:0] a_lo, a_hi, b_lo, b_hi;
  logic       a_dflt, b_dflt;
  logic [2:0] net_sel;
  logic [3:0] out_lo, out_hi;
  int         n_run;
  int         n_fail;

  strn_resolver u0 (
    .a_lo(a_lo), .a_hi(a_hi), .a_dflt(a_dflt),
    .b_lo(b_lo), .b_hi(b_hi), .b_dflt(b_dflt),
    .net_sel(net_sel), .out_lo(out_lo), .out_hi(out_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req[3:0], net[2:0], alo, ahi, adflt, blo, bhi, bdflt, exp_lo, exp_hi}
  localparam int NV = 25;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1, 3'd0, 4'd1,  4'd1,  1'b0, 4'd13, 4'd13, 1'b0, 4'd1,  4'd1 },  // R1
    {4'd1, 3'd0, 4'd4,  4'd4,  1'b0, 4'd13, 4'd13, 1'b0, 4'd13, 4'd13},  // R1
    {4'd2, 3'd0, 4'd1,  4'd1,  1'b0, 4'd14, 4'd14, 1'b0, 4'd1,  4'd14},  // R2
    {4'd2, 3'd1, 4'd1,  4'd1,  1'b0, 4'd14, 4'd14, 1'b0, 4'd1,  4'd1 },  // R2
    {4'd2, 3'd2, 4'd1,  4'd1,  1'b0, 4'd14, 4'd14, 1'b0, 4'd14, 4'd14},  // R2
    {4'd2, 3'd0, 4'd5,  4'd5,  1'b0, 4'd10, 4'd10, 1'b0, 4'd5,  4'd10},  // R2
    {4'd2, 3'd1, 4'd1,  4'd14, 1'b0, 4'd1,  4'd1,  1'b0, 4'd1,  4'd1 },  // R2
    {4'd2, 3'd2, 4'd1,  4'd14, 1'b0, 4'd1,  4'd1,  1'b0, 4'd1,  4'd14},  // R2
    {4'd3, 3'd0, 4'd13, 4'd15, 1'b0, 4'd4,  4'd4,  1'b0, 4'd13, 4'd15},  // R3
    {4'd4, 3'd0, 4'd9,  4'd14, 1'b0, 4'd13, 4'd13, 1'b0, 4'd13, 4'd14},  // R4
    {4'd5, 3'd0, 4'd11, 4'd14, 1'b0, 4'd2,  4'd2,  1'b0, 4'd2,  4'd14},  // R5
    {4'd5, 3'd0, 4'd0,  4'd5,  1'b0, 4'd12, 4'd12, 1'b0, 4'd0,  4'd12},  // R5
    {4'd6, 3'd0, 4'd2,  4'd6,  1'b0, 4'd9,  4'd11, 1'b0, 4'd2,  4'd11},  // R6
    {4'd6, 3'd0, 4'd2,  4'd7,  1'b0, 4'd8,  4'd11, 1'b0, 4'd2,  4'd11},  // R6
    {4'd7, 3'd0, 4'd7,  4'd7,  1'b0, 4'd7,  4'd7,  1'b0, 4'd7,  4'd8 },  // R7
    {4'd7, 3'd1, 4'd7,  4'd7,  1'b0, 4'd8,  4'd8,  1'b0, 4'd7,  4'd8 },  // R7
    {4'd8, 3'd3, 4'd7,  4'd7,  1'b0, 4'd8,  4'd8,  1'b0, 4'd2,  4'd2 },  // R8
    {4'd8, 3'd4, 4'd7,  4'd8,  1'b0, 4'd8,  4'd8,  1'b0, 4'd13, 4'd13},  // R8
    {4'd8, 3'd3, 4'd14, 4'd14, 1'b0, 4'd8,  4'd8,  1'b0, 4'd14, 4'd14},  // R8
    {4'd8, 3'd4, 4'd4,  4'd4,  1'b0, 4'd8,  4'd8,  1'b0, 4'd13, 4'd13},  // R8
    {4'd8, 3'd3, 4'd4,  4'd10, 1'b0, 4'd7,  4'd7,  1'b0, 4'd2,  4'd2 },  // R8
    {4'd9, 3'd0, 4'd4,  4'd11, 1'b1, 4'd2,  4'd2,  1'b0, 4'd14, 4'd14},  // R9
    {4'd9, 3'd0, 4'd0,  4'd4,  1'b1, 4'd13, 4'd13, 1'b0, 4'd1,  4'd1 },  // R9
    {4'd10,3'd0, 4'd14, 4'd11, 1'b0, 4'd2,  4'd2,  1'b0, 4'd2,  4'd14},  // R10
    {4'd12,3'd6, 4'd1,  4'd1,  1'b0, 4'd14, 4'd14, 1'b0, 4'd1,  4'd14}   // R12
  };

  task automatic apply_chk(input int req, input logic [2:0] nt,
                           input logic [3:0] alo, input logic [3:0] ahi, input logic ad,
                           input logic [3:0] blo, input logic [3:0] bhi, input logic bd,
                           input logic [3:0] elo, input logic [3:0] ehi);
    @(negedge clk);
    net_sel = nt;
    a_lo = alo; a_hi = ahi; a_dflt = ad;
    b_lo = blo; b_hi = bhi; b_dflt = bd;
    #2;
    n_run++;
    if (out_lo !== elo || out_hi !== ehi) begin
      n_fail++;
      $display("FAIL R%0d: actual lo=%0d hi=%0d expected lo=%0d hi=%0d", req, out_lo, out_hi, elo, ehi);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    net_sel = 3'd0;
    a_lo = 4'd7; a_hi = 4'd7; a_dflt = 1'b0;
    b_lo = 4'd7; b_hi = 4'd7; b_dflt = 1'b0;
    // initial state: both undriven on a plain net gives z (R7)
    apply_chk(7, 3'd0, 4'd7, 4'd7, 1'b0, 4'd7, 4'd7, 1'b0, 4'd7, 4'd8);

    for (int k = 0; k < NV; k++) begin
      apply_chk(int'(VEC[k][32:29]), VEC[k][28:26], VEC[k][25:22], VEC[k][21:18], VEC[k][17],
                VEC[k][16:13], VEC[k][12:9], VEC[k][8], VEC[k][7:4], VEC[k][3:0]);
      // R11: same vector with the drivers swapped
      apply_chk(11, VEC[k][28:26], VEC[k][16:13], VEC[k][12:9], VEC[k][8],
                VEC[k][25:22], VEC[k][21:18], VEC[k][17], VEC[k][7:4], VEC[k][3:0]);
    end

    // R9: both drivers default strong, opposite sides, plain net -> StX
    apply_chk(9, 3'd0, 4'd3, 4'd3, 1'b1, 4'd12, 4'd12, 1'b1, 4'd1, 4'd14);
    // R9 with reversed endpoints (R10): upper endpoint 9 picks the 1 side
    apply_chk(10, 3'd0, 4'd9, 4'd0, 1'b1, 4'd7, 4'd7, 1'b0, 4'd14, 4'd14);
    // R8: pulled-high net with a strong 0 against an ambiguous weak driver
    apply_chk(8, 3'd4, 4'd1, 4'd1, 1'b0, 4'd8, 4'd11, 1'b0, 4'd1, 4'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule